// File: doc/BRIEF.md
# DAC Update and Busy Sequencer

This block is the control state machine of a multichannel DAC. It decides when the channel register bank may move its input registers into the DAC registers. It also decides when every channel is forced to the clear code and when all registers return to their power-on defaults. It watches four things: a calculation-start pulse from the serial front end, an active-low load strobe pin, a clear pin and a reset pin. It reports its own activity on an active-low BUSY output and on an interface-enable level. It issues its commands as single-cycle pulses.

The three pins are asynchronous. Each one passes through a synchroniser, and only its falling edge in the system clock domain counts.

- **Reset.** A reset edge, or the power-on reset, holds BUSY low and the host interface off for a programmable number of cycles. Load strobes that arrive in that window are dropped.
- **Clear.** A clear edge broadcasts the clear code to all channels and holds BUSY low for its own programmable window. No load strobe is honoured while the clear pin stays low.
- **Calculation.** A calculation keeps BUSY low for a fixed number of cycles. A load strobe seen during a calculation is remembered and applied in the cycle BUSY returns high. Any reset or clear drops the remembered strobe.

States:
- `ST_RESET`: register-reset window, BUSY low, interface off.
- `ST_IDLE`: BUSY high.
- `ST_CALC`: calculation window, BUSY low.
- `ST_CLEAR`: clear window, BUSY low.

Transitions:
- Power-on reset enters `ST_RESET`.
- `ST_RESET` goes to `ST_IDLE` when its timer expires.
- `ST_IDLE` goes to `ST_CALC` on calc-start.
- `ST_CALC` goes back to `ST_CALC` (restart) on a new calc-start.
- `ST_CALC` goes to `ST_IDLE` when its timer expires. A transfer is issued at that moment if a strobe is pending.
- Any state except `ST_RESET` goes to `ST_CLEAR` on a clear edge.
- `ST_CLEAR` goes to `ST_IDLE` when its timer expires.
- Any state except `ST_RESET` goes to `ST_RESET` on a reset edge. This takes priority over a clear edge in the same cycle.

Top module: `dac_update_sequencer`

## Requirements
- R1: While `por_n` is low, `busy_n` and `if_en` are 0 and `regrst_pulse` is 1. After `por_n` rises, `regrst_pulse` drops at the first clock edge. `busy_n` and `if_en` rise at the RST_CYCLES-th clock edge after the release.
- R2: A `calc_start` high at a clock edge in `ST_IDLE` drives `busy_n` low from that edge for exactly CALC_CYCLES cycles.
- R3: A falling edge on `ldac_n` while BUSY is high and `clr_n` is high gives one `xfer_pulse` of one cycle. The pulse follows the third clock edge after the pin change: two synchroniser stages, then the state register.
- R4: A falling edge on `ldac_n` during a calculation gives no transfer while BUSY is low. Exactly one `xfer_pulse` is given, in the cycle `busy_n` returns to 1.
- R5: A falling edge on `rst_n` gives one `regrst_pulse`. It drives `busy_n` and `if_en` low for exactly RST_CYCLES cycles, and it discards any pending load.
- R6: Falling edges on `ldac_n` during a reset sequence are discarded. No `xfer_pulse` follows the sequence.
- R7: Once a reset sequence ends, a `rst_n` level still held low has no effect. BUSY stays high and load strobes are served.
- R8: A falling edge on `clr_n` gives one `clear_pulse` and drives `busy_n` low for exactly CLR_CYCLES cycles. It also discards any pending load.
- R9: A falling edge on `ldac_n` while `clr_n` is held low produces no `xfer_pulse`.
- R10: When reset and clear edges arrive in the same cycle, the reset wins: `regrst_pulse` is given and `clear_pulse` is not. At most one of the three command pulses is high in any cycle.
- R11: A `calc_start` during a calculation restarts the window. BUSY stays low for CALC_CYCLES cycles after the last start.
- R12: A `calc_start` during a reset sequence is ignored. The sequence still ends after RST_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| calc_start | input | 1 | One-cycle pulse from the serial front end starting a calculation |
| ldac_n | input | 1 | Load strobe pin, active low, asynchronous |
| clr_n | input | 1 | Clear pin, falling-edge sensitive, asynchronous |
| rst_n | input | 1 | Register reset pin, falling-edge sensitive, asynchronous |
| busy_n | output | 1 | Active-low busy indication |
| if_en | output | 1 | Host interface enable, low during reset sequences |
| xfer_pulse | output | 1 | One-cycle command: copy input registers into DAC registers |
| clear_pulse | output | 1 | One-cycle command: load every channel from the clear code |
| regrst_pulse | output | 1 | One-cycle command: restore registers to power-on defaults |

## Verification
The load strobe is applied in four settings: with the block idle, during a calculation, during a reset sequence, and with the clear pin held low. Each setting separates the immediate, deferred, discarded and blocked paths.

Pending loads are also interrupted by a clear edge and by a reset edge, which shows that both drop the remembered strobe. Back-to-back calculation starts show the window restart. Simultaneous reset and clear edges show the priority. A reset pin left low after its sequence shows that only the edge counts.

// File: rtl/dus_pkg.sv
package dus_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_CALC  = 2'd2,
        ST_CLEAR = 2'd3
    } dus_state_e;

    localparam int PIN_LDAC = 0;
    localparam int PIN_CLR  = 1;
    localparam int PIN_RST  = 2;
    localparam int PIN_COUNT = 3;

endpackage

// File: rtl/dus_sync.sv
module dus_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_lvl,
    output logic [WIDTH-1:0] pin_fall
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_async[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign pin_lvl[g]  = chain_q[STAGES-1];
        assign pin_fall[g] = prev_q & ~chain_q[STAGES-1];
    end

endmodule

// File: rtl/dus_timer.sv
module dus_timer #(
    parameter int CW       = 16,
    parameter int INIT_VAL = 0
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= CW'(INIT_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!por_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("timer step"); // R2

    AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0)) else $error("timer hold"); // R11

endmodule

// File: rtl/dac_update_sequencer.sv
module dac_update_sequencer #(
    parameter int CALC_CYCLES = 40,
    parameter int CLR_CYCLES  = 3000,
    parameter int RST_CYCLES  = 54000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic calc_start,
    input  logic ldac_n,
    input  logic clr_n,
    input  logic rst_n,
    output logic busy_n,
    output logic if_en,
    output logic xfer_pulse,
    output logic clear_pulse,
    output logic regrst_pulse
);

    import dus_pkg::*;

    localparam int MAX_AB  = (CALC_CYCLES > CLR_CYCLES) ? CALC_CYCLES : CLR_CYCLES;
    localparam int MAX_CYC = (MAX_AB > RST_CYCLES) ? MAX_AB : RST_CYCLES;
    localparam int CW      = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] CALC_LOAD = CW'(CALC_CYCLES - 1);
    localparam logic [CW-1:0] CLR_LOAD  = CW'(CLR_CYCLES - 1);
    localparam logic [CW-1:0] RST_LOAD  = CW'(RST_CYCLES - 1);

    // pin synchronisation and edge detection
    logic [PIN_COUNT-1:0] pin_raw;
    logic [PIN_COUNT-1:0] pin_lvl;
    logic [PIN_COUNT-1:0] pin_fall;

    assign pin_raw[PIN_LDAC] = ldac_n;
    assign pin_raw[PIN_CLR]  = clr_n;
    assign pin_raw[PIN_RST]  = rst_n;

    dus_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .por_n     (por_n),
        .pin_async (pin_raw),
        .pin_lvl   (pin_lvl),
        .pin_fall  (pin_fall)
    );

    logic ldac_fall;
    logic clr_fall;
    logic rst_fall;
    logic clr_high;
    logic ldac_ok;

    assign ldac_fall = pin_fall[PIN_LDAC];
    assign clr_fall  = pin_fall[PIN_CLR];
    assign rst_fall  = pin_fall[PIN_RST];
    assign clr_high  = pin_lvl[PIN_CLR];
    assign ldac_ok   = ldac_fall & clr_high;

    // window timer
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;

    dus_timer #(
        .CW       (CW),
        .INIT_VAL (RST_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .por_n    (por_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // next-state decision
    dus_state_e state_q;
    dus_state_e state_d;
    logic       pend_q;
    logic       pend_d;
    logic       xfer_d;
    logic       clear_d;
    logic       regrst_d;

    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        xfer_d   = 1'b0;
        clear_d  = 1'b0;
        regrst_d = 1'b0;

        unique case (state_q)
            ST_RESET: begin
                pend_d = 1'b0;
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (calc_start) begin
                    state_d  = ST_CALC;
                    tmr_load = 1'b1;
                    tmr_val  = CALC_LOAD;
                end
                if (ldac_ok) begin
                    xfer_d = 1'b1;
                end
            end
            ST_CALC: begin
                if (ldac_ok) begin
                    pend_d = 1'b1;
                end
                if (calc_start) begin
                    tmr_load = 1'b1;
                    tmr_val  = CALC_LOAD;
                end else if (tmr_done) begin
                    state_d = ST_IDLE;
                    xfer_d  = pend_q | ldac_ok;
                    pend_d  = 1'b0;
                end
            end
            ST_CLEAR: begin
                pend_d = 1'b0;
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_RESET;
            end
        endcase

        if (state_q != ST_RESET && clr_fall) begin
            state_d  = ST_CLEAR;
            tmr_load = 1'b1;
            tmr_val  = CLR_LOAD;
            pend_d   = 1'b0;
            xfer_d   = 1'b0;
            clear_d  = 1'b1;
        end

        if (state_q != ST_RESET && rst_fall) begin
            state_d  = ST_RESET;
            tmr_load = 1'b1;
            tmr_val  = RST_LOAD;
            pend_d   = 1'b0;
            xfer_d   = 1'b0;
            clear_d  = 1'b0;
            regrst_d = 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_RESET;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            busy_n       <= 1'b0;
            if_en        <= 1'b0;
            xfer_pulse   <= 1'b0;
            clear_pulse  <= 1'b0;
            regrst_pulse <= 1'b1;
        end else begin
            busy_n       <= (state_d == ST_IDLE);
            if_en        <= (state_d != ST_RESET);
            xfer_pulse   <= xfer_d;
            clear_pulse  <= clear_d;
            regrst_pulse <= regrst_d;
        end
    end

    AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0({xfer_pulse, clear_pulse, regrst_pulse})) else $error("commands overlap"); // R10

    AST_CALC_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_IDLE && calc_start && !rst_fall && !clr_fall) |=> !busy_n) else $error("calc busy"); // R2

    AST_XFER_NOT_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        xfer_pulse |-> busy_n) else $error("xfer while busy"); // R4

    AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        clear_pulse |-> !busy_n) else $error("clear without busy"); // R8

    AST_REGRST_IF_OFF: assert property (@(posedge clk) disable iff (!por_n)
        regrst_pulse |-> (!busy_n && !if_en)) else $error("regrst with interface on"); // R5

    AST_NO_XFER_IF_OFF: assert property (@(posedge clk) disable iff (!por_n)
        !if_en |-> !xfer_pulse) else $error("xfer during reset"); // R6

    AST_PEND_DROP_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_RESET && clr_fall) |=> !pend_q) else $error("pending kept over clear"); // R8

endmodule

// File: tb/dac_update_sequencer_tb.sv
`timescale 1ns/1ps
module dac_update_sequencer_tb_top;

    localparam int CALC = 6;
    localparam int CLRC = 10;
    localparam int RSTC = 20;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic calc_start = 1'b0;
    logic ldac_n = 1'b1;
    logic clr_n = 1'b1;
    logic rst_n = 1'b1;
    logic busy_n, if_en, xfer_pulse, clear_pulse, regrst_pulse;

    int checks = 0;
    int errors = 0;
    int n_xfer = 0;
    int n_clear = 0;
    int n_regrst = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dac_update_sequencer #(
        .CALC_CYCLES (CALC),
        .CLR_CYCLES  (CLRC),
        .RST_CYCLES  (RSTC),
        .SYNC_STAGES (2)
    ) dut_i (
        .clk          (clk),
        .por_n        (por_n),
        .calc_start   (calc_start),
        .ldac_n       (ldac_n),
        .clr_n        (clr_n),
        .rst_n        (rst_n),
        .busy_n       (busy_n),
        .if_en        (if_en),
        .xfer_pulse   (xfer_pulse),
        .clear_pulse  (clear_pulse),
        .regrst_pulse (regrst_pulse)
    );

    always @(negedge clk) begin
        if (por_n) begin
            if (xfer_pulse)   n_xfer++;
            if (clear_pulse)  n_clear++;
            if (regrst_pulse) n_regrst++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        #1;
        n_xfer = 0;
        n_clear = 0;
        n_regrst = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_busy(output int n);
        n = 0;
        while (busy_n == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_calc();
        calc_start = 1'b1;
        @(negedge clk);
        calc_start = 1'b0;
    endtask

    task automatic test_por();
        int n;
        idle(3);
        chk("R1 busy_n in por", busy_n, 0);
        chk("R1 if_en in por", if_en, 0);
        chk("R1 regrst in por", regrst_pulse, 1);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 regrst drops", regrst_pulse, 0);
        measure_busy(n);
        chk("R1 por busy length", n + 1, RSTC);
        chk("R1 if_en after", if_en, 1);
        idle(2);
    endtask

    task automatic test_idle_load();
        clear_counts();
        ldac_n = 1'b0;
        idle(2);
        chk("R3 no early xfer", xfer_pulse, 0);
        @(negedge clk);
        chk("R3 xfer at third edge", xfer_pulse, 1);
        @(negedge clk);
        chk("R3 xfer one cycle", xfer_pulse, 0);
        ldac_n = 1'b1;
        idle(4);
        #1;
        chk("R3 xfer count", n_xfer, 1);
    endtask

    task automatic test_calc();
        int n;
        clear_counts();
        pulse_calc();
        measure_busy(n);
        chk("R2 calc busy length", n, CALC);
        idle(2);
        #1;
        chk("R2 no xfer", n_xfer, 0);
    endtask

    task automatic test_deferred_load();
        int n;
        clear_counts();
        calc_start = 1'b1;
        @(negedge clk);
        calc_start = 1'b0;
        ldac_n = 1'b0;
        measure_busy(n);
        chk("R4 xfer when busy ends", xfer_pulse, 1);
        #1;
        chk("R4 xfer count", n_xfer, 1);
        ldac_n = 1'b1;
        idle(4);
        #1;
        chk("R4 single xfer", n_xfer, 1);
    endtask

    task automatic test_restart();
        int n;
        pulse_calc();
        idle(2);
        pulse_calc();
        measure_busy(n);
        chk("R11 restarted window", n, CALC);
        idle(2);
    endtask

    task automatic test_clear();
        int n;
        clear_counts();
        calc_start = 1'b1;
        @(negedge clk);
        calc_start = 1'b0;
        ldac_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b0;
        idle(3);
        chk("R8 clear pulse", clear_pulse, 1);
        measure_busy(n);
        chk("R8 clear busy length", n, CLRC);
        idle(3);
        #1;
        chk("R8 pending dropped", n_xfer, 0);
        chk("R8 clear count", n_clear, 1);
        ldac_n = 1'b1;
        idle(4);
    endtask

    task automatic test_clr_held();
        clear_counts();
        ldac_n = 1'b0;
        idle(6);
        #1;
        chk("R9 no xfer with clr low", n_xfer, 0);
        chk("R9 busy stays high", busy_n, 1);
        ldac_n = 1'b1;
        clr_n = 1'b1;
        idle(4);
    endtask

    task automatic test_reset_pin();
        int n;
        clear_counts();
        calc_start = 1'b1;
        @(negedge clk);
        calc_start = 1'b0;
        ldac_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        chk("R5 regrst pulse", regrst_pulse, 1);
        chk("R5 if_en off", if_en, 0);
        fork
            measure_busy(n);
            begin
                idle(3);
                ldac_n = 1'b1;
                idle(4);
                ldac_n = 1'b0;
                idle(2);
                pulse_calc();
            end
        join
        chk("R5 reset busy length", n, RSTC);
        chk("R12 calc ignored, if_en back", if_en, 1);
        idle(4);
        #1;
        chk("R6 no xfer after reset", n_xfer, 0);
        chk("R5 regrst count", n_regrst, 1);
        idle(10);
        chk("R7 busy stays high with rst low", busy_n, 1);
        clear_counts();
        ldac_n = 1'b1;
        idle(3);
        ldac_n = 1'b0;
        idle(5);
        #1;
        chk("R7 load served after reset", n_xfer, 1);
        chk("R7 no new regrst", n_regrst, 0);
        ldac_n = 1'b1;
        rst_n = 1'b1;
        idle(4);
    endtask

    task automatic test_priority();
        int n;
        clear_counts();
        rst_n = 1'b0;
        clr_n = 1'b0;
        idle(3);
        chk("R10 regrst wins", regrst_pulse, 1);
        chk("R10 no clear", clear_pulse, 0);
        measure_busy(n);
        chk("R10 reset length", n, RSTC);
        #1;
        chk("R10 clear count", n_clear, 0);
        rst_n = 1'b1;
        clr_n = 1'b1;
        idle(4);
    endtask

    initial begin
        test_por();
        test_idle_load();
        test_calc();
        test_deferred_load();
        test_restart();
        test_clear();
        test_clr_held();
        test_reset_pin();
        test_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule